// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the configuration of a group of general-purpose I/O pads behind a 32-bit register port. Each access takes one cycle. Every pad owns a two-word record in a pad table. The table's byte offset is published in a read-only register, so software finds pad `n` at that offset plus `8*n`. The first word of a record carries the output value, the sampled input, separate transmit and receive disables, a mode field, receive inversion, event and override controls. The second word stores termination settings as plain bits.

The bank drives the pad output and output-enable lines from these fields. It samples the pad inputs into the read-back state and hands an optionally inverted copy of each received level to a separate interrupt detector. Global registers hold an interrupt-line routing bit, a 2-bit owner code per pad, and a host-software ownership bit per pad. A pad whose owner code is not the host is locked against configuration access from this port.

Top module: `gpio_pad_regbank`

## Requirements
- R1: After reset, every pad's first word reads 0x00000100 (transmit disable set, all else 0), every second word reads 0, and `pad_oe` and `pad_out` are all 0.
- R2: A read (`bus_sel`=1, `bus_wr`=0) returns its data on `bus_rdata` with `bus_rvalid`=1 in the next cycle. In any cycle after a write or idle cycle, `bus_rvalid`=0 and `bus_rdata`=0.
- R3: Offset 0x00C reads the pad table's byte offset (parameter `TABLE_BASE`) and ignores writes. Pad `n` word 0 is at `TABLE_BASE+8n` and word 1 is at `TABLE_BASE+8n+4`.
- R4: Word 0 stores only these fields: bit 0 output value, bit 8 transmit disable, bit 9 receive disable, bits 13:10 mode, bit 23 receive invert, bit 24 filter-bypass select, bits 26:25 event config, bit 28 receive force-high, bit 29 pad-state select (write mask 0x37803F01). Bit 1 reads the sampled input and writes to it are ignored. All other bits read 0.
- R5: Word 1 stores bits 17:8 (standby termination 9:8, termination 13:10, standby state 17:14) and reads 0 elsewhere.
- R6: `pad_oe[n]` is 1 exactly when pad `n` has mode 0 and transmit disable 0. `pad_out[n]` equals the output value bit while enabled and is 0 otherwise.
- R7: While receive disable is 0, the sampled-input bit takes `pad_in[n]` at each clock, or 1 when force-high (bit 28) is set. While receive disable is 1, the bit holds its value.
- R8: Offset 0x010 stores only bit 3, which drives `irq_line_sel` (0 = first interrupt line).
- R9: Owner registers start at 0x020, one word per 8 pads. Pad `n` uses bits `4*(n%8)+1 : 4*(n%8)` of word `n/8`. Code 0 is host. Other bits read 0.
- R10: Host-software ownership words at 0x080 and 0x084 hold bit `n%32` for pad `n`. Bits for pads that do not exist read 0.
- R11: Config words of a pad with a nonzero owner code read 0 and ignore writes.
- R12: Undefined offsets, addresses with nonzero bits 1:0, and table slots past the last pad read 0 and ignore writes.
- R13: `rx_level[n]` is the sampled-input bit XOR the receive-invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | NUM_PADS | Pad input levels |
| pad_out | output | NUM_PADS | Pad output values |
| pad_oe | output | NUM_PADS | Pad output enables |
| rx_level | output | NUM_PADS | Received level toward interrupt detection |
| irq_line_sel | output | 1 | Interrupt line routing select |

## Verification
The bench locks a pad by giving it a foreign owner, then writes and reads its record. A bank that ignored ownership would enable the output or return live data there. It writes all-ones to both words and to the pad-base register. A wrong mask would leak reserved bits, let the sampled-input bit be overwritten, or make the table base writable. It toggles the inputs while receive is disabled and while force-high is set. A design that kept sampling, or that ignored the override, would return the wrong bit 1. Table slots past the last pad, owner words past the last group and misaligned addresses are also accessed. An off-by-one decode would alias them onto real pads.

// File: rtl/gpio_pad_regbank.sv
module gpio_pad_regbank #(
  parameter int NUM_PADS   = 40,
  parameter int ADDR_W     = 12,
  parameter int TABLE_BASE = 'h400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] rx_level,
  output logic                irq_line_sel
);

  localparam int OWN_WORDS = (NUM_PADS + 7) / 8;
  localparam int HSW_WORDS = (NUM_PADS + 31) / 32;
  localparam int PIDX_W    = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int AX        = ADDR_W + 1;
  localparam logic [31:0] CFG0_MASK = 32'h3780_3F01;
  localparam logic [31:0] CFG0_RST  = 32'h0000_0100;
  localparam logic [31:0] CFG1_MASK = 32'h0003_FF00;
  localparam logic [AX-1:0] A_PADBASE = AX'('h00C);
  localparam logic [AX-1:0] A_MISC    = AX'('h010);
  localparam logic [AX-1:0] A_OWN     = AX'('h020);
  localparam logic [AX-1:0] A_OWN_END = AX'('h020 + 4 * OWN_WORDS);
  localparam logic [AX-1:0] A_HSW     = AX'('h080);
  localparam logic [AX-1:0] A_HSW_END = AX'('h080 + 4 * HSW_WORDS);
  localparam logic [AX-1:0] A_TBL     = AX'(TABLE_BASE);
  localparam logic [AX-1:0] A_TBL_END = AX'(TABLE_BASE + 8 * NUM_PADS);

  logic [AX-1:0] ax;
  logic aligned, wr_en, rd_en;
  logic hit_pb, hit_misc, in_own, in_hsw, in_tbl, wsel;
  logic [PIDX_W-1:0] pidx;
  logic [2:0] own_idx;

  assign ax       = {1'b0, bus_addr};
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign hit_pb   = aligned && (ax == A_PADBASE);
  assign hit_misc = aligned && (ax == A_MISC);
  assign in_own   = aligned && (ax >= A_OWN) && (ax < A_OWN_END);
  assign in_hsw   = aligned && (ax >= A_HSW) && (ax < A_HSW_END);
  assign in_tbl   = aligned && (ax >= A_TBL) && (ax < A_TBL_END);
  assign wsel     = ax[2];
  assign pidx     = PIDX_W'((ax - A_TBL) >> 3);
  assign own_idx  = 3'((ax - A_OWN) >> 2);

  logic [NUM_PADS-1:0][31:0] cfg0_v;
  logic [NUM_PADS-1:0][31:0] cfg1_v;
  logic [NUM_PADS-1:0][1:0]  owner_v;
  logic [NUM_PADS-1:0]       hsw_q;
  logic [NUM_PADS-1:0]       rx_q;
  logic [NUM_PADS-1:0]       rx_dis_v;
  logic [NUM_PADS-1:0]       rx_raw_v;
  logic                      route_q;

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    localparam logic [2:0] OWORD = 3'(i / 8);
    localparam int         OSH   = (i % 8) * 4;
    localparam logic       HWORD = 1'(i / 32);
    logic [31:0] cfg0_q, cfg1_q;
    logic [1:0]  own_q;
    logic        hsw_r, rx_r, cfg_wr;

    assign cfg_wr = wr_en && in_tbl && (pidx == PIDX_W'(i)) && (own_q == 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg0_q <= CFG0_RST;
        cfg1_q <= '0;
        own_q  <= '0;
        hsw_r  <= 1'b0;
        rx_r   <= 1'b0;
      end else begin
        if (cfg_wr && !wsel) cfg0_q <= bus_wdata & CFG0_MASK;
        if (cfg_wr && wsel)  cfg1_q <= bus_wdata & CFG1_MASK;
        if (wr_en && in_own && own_idx == OWORD) own_q <= bus_wdata[OSH +: 2];
        if (wr_en && in_hsw && wsel == HWORD)    hsw_r <= bus_wdata[i % 32];
        if (!cfg0_q[9]) rx_r <= cfg0_q[28] | pad_in[i];
      end
    end

    assign cfg0_v[i]   = cfg0_q;
    assign cfg1_v[i]   = cfg1_q;
    assign owner_v[i]  = own_q;
    assign hsw_q[i]    = hsw_r;
    assign rx_q[i]     = rx_r;
    assign rx_dis_v[i] = cfg0_q[9];
    assign rx_raw_v[i] = cfg0_q[28];
    assign pad_oe[i]   = (cfg0_q[13:10] == 4'd0) && !cfg0_q[8];
    assign pad_out[i]  = pad_oe[i] & cfg0_q[0];
    assign rx_level[i] = rx_r ^ cfg0_q[23];
  end

  logic [63:0] hsw_all;
  logic [31:0] rd_d;
  assign hsw_all = 64'(hsw_q);

  always_comb begin
    rd_d = '0;
    if (hit_pb) rd_d = 32'(TABLE_BASE);
    else if (hit_misc) rd_d[3] = route_q;
    else if (in_own) begin
      for (int p = 0; p < NUM_PADS; p++)
        if (3'(p / 8) == own_idx) rd_d[(p % 8) * 4 +: 2] = owner_v[p];
    end
    else if (in_hsw) rd_d = wsel ? hsw_all[63:32] : hsw_all[31:0];
    else if (in_tbl && owner_v[pidx] == 2'd0)
      rd_d = wsel ? cfg1_v[pidx] : (cfg0_v[pidx] | {30'b0, rx_q[pidx], 1'b0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q    <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (wr_en && hit_misc) route_q <= bus_wdata[3];
      bus_rvalid <= rd_en;
      bus_rdata  <= rd_en ? rd_d : '0;
    end
  end

  assign irq_line_sel = route_q;

endmodule

// File: rtl/gpio_pad_regbank_chk.sv
module gpio_pad_regbank_chk #(
  parameter int NUM_PADS   = 40,
  parameter int ADDR_W     = 12,
  parameter int TABLE_BASE = 'h400
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic                bus_rvalid,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] rx_state,
  input logic [NUM_PADS-1:0] rx_dis,
  input logic [NUM_PADS-1:0] rx_raw1
);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid); // R2
  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr) |=> !bus_rvalid); // R2
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> (bus_rdata == 32'd0)); // R2
  AST_PADBASE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'('h00C)) |=> (bus_rdata == 32'(TABLE_BASE))); // R3
  AST_OE_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pad_oe)); // R6
  AST_RX_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((rx_state ^ $past(rx_state)) & $past(rx_dis)) == '0)); // R7
  AST_RX_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(rx_raw1 & ~rx_dis) & ~rx_state) == '0)); // R7

endmodule

bind gpio_pad_regbank gpio_pad_regbank_chk #(
  .NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .pad_oe(pad_oe), .rx_state(rx_q), .rx_dis(rx_dis_v), .rx_raw1(rx_raw_v)
);

// File: tb/sim_gpio_pad_regbank.sv
module sim_gpio_pad_regbank;
  localparam int NP = 40, AW = 12, TB = 'h400, OWNW = (NP + 7) / 8;
  localparam logic [31:0] M0 = 32'h3780_3F01, M1 = 32'h0003_FF00;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NP-1:0] pins = '0;
  wire [31:0] rdata;
  wire rvalid, route;
  wire [NP-1:0] pout, poe, rxl;

  int checks = 0, errors = 0;

  gpio_pad_regbank #(.NUM_PADS(NP), .ADDR_W(AW), .TABLE_BASE(TB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid), .pad_in(pins),
    .pad_out(pout), .pad_oe(poe), .rx_level(rxl), .irq_line_sel(route));

  logic [31:0] m_w0 [NP];
  logic [31:0] m_w1 [NP];
  logic [1:0]  m_own [NP];
  logic [63:0] m_hsw;
  logic        m_rx [NP];
  logic        m_route;

  function automatic bit in_tbl(logic [AW-1:0] a);
    return a[1:0] == 0 && int'(a) >= TB && int'(a) < TB + 8 * NP;
  endfunction
  function automatic bit in_own(logic [AW-1:0] a);
    return a[1:0] == 0 && int'(a) >= 'h20 && int'(a) < 'h20 + 4 * OWNW;
  endfunction

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    logic [31:0] r = 0;
    int p;
    if (a[1:0] != 0) return 0;
    if (a == 'h00C) return TB;
    if (a == 'h010) return {28'b0, m_route, 3'b0};
    if (in_own(a)) begin
      for (int q = 0; q < NP; q++)
        if (q / 8 == (int'(a) - 'h20) / 4) r[(q % 8) * 4 +: 2] = m_own[q];
      return r;
    end
    if (a == 'h080) return m_hsw[31:0];
    if (a == 'h084 && NP > 32) return m_hsw[63:32];
    if (in_tbl(a)) begin
      p = (int'(a) - TB) / 8;
      if (m_own[p] != 0) return 0;
      return a[2] ? m_w1[p] : (m_w0[p] | {30'b0, m_rx[p], 1'b0});
    end
    return 0;
  endfunction

  function automatic string tag_of(logic [AW-1:0] a);
    if (a[1:0] != 0) return "R12";
    if (a == 'h00C) return "R3";
    if (a == 'h010) return "R8";
    if (in_own(a)) return "R9";
    if (a == 'h080 || (a == 'h084 && NP > 32)) return "R10";
    if (in_tbl(a)) begin
      if (m_own[(int'(a) - TB) / 8] != 0) return "R11";
      return a[2] ? "R5" : "R4";
    end
    return "R12";
  endfunction

  task automatic mdl_write(logic [AW-1:0] a, logic [31:0] d);
    int p;
    if (a[1:0] != 0) return;
    if (a == 'h010) m_route = d[3];
    if (in_own(a))
      for (int q = 0; q < NP; q++)
        if (q / 8 == (int'(a) - 'h20) / 4) m_own[q] = d[(q % 8) * 4 +: 2];
    for (int q = 0; q < NP; q++)
      if (int'(a) == 'h80 + 4 * (q / 32)) m_hsw[q] = d[q % 32];
    if (in_tbl(a)) begin
      p = (int'(a) - TB) / 8;
      if (m_own[p] == 0) begin
        if (a[2]) m_w1[p] = d & M1;
        else m_w0[p] = d & M0;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NP; q++) begin
        m_w0[q] = 32'h100; m_w1[q] = 0; m_own[q] = 0; m_rx[q] = 0;
      end
      m_hsw = 0; m_route = 0;
    end else begin
      for (int q = 0; q < NP; q++)
        if (!m_w0[q][9]) m_rx[q] = m_w0[q][28] | pins[q];
      if (sel && wr) mdl_write(addr, wdata);
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_pads();
    logic [63:0] eo = 0, ev = 0, er = 0;
    for (int q = 0; q < NP; q++) begin
      eo[q] = (m_w0[q][13:10] == 0) && !m_w0[q][8];
      ev[q] = eo[q] & m_w0[q][0];
      er[q] = m_rx[q] ^ m_w0[q][23];
    end
    chk("R6", "pad_oe", 64'(poe), eo);
    chk("R6", "pad_out", 64'(pout), ev);
    chk("R13", "rx_level", 64'(rxl), er);
    chk("R8", "irq_line_sel", 64'(route), 64'(m_route));
  endtask

  task automatic op(bit s, bit w, logic [AW-1:0] a, logic [31:0] d, logic [NP-1:0] pv, string tag);
    logic [31:0] e;
    string t;
    bit rd;
    rd = s && !w;
    e = exp_rd(a);
    t = rd ? ((tag == "") ? tag_of(a) : tag) : "R2";
    sel = s; wr = w; addr = a; wdata = d; pins = pv;
    @(negedge clk);
    chk(t, "rvalid", 64'(rvalid), 64'(rd));
    chk(t, "rdata", 64'(rdata), rd ? 64'(e) : 64'd0);
    chk_pads();
    sel = 0; wr = 0;
  endtask

  function automatic logic [NP-1:0] rpins();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [AW-1:0] raddr();
    case ($urandom % 8)
      0: return 'h00C;
      1: return 'h010;
      2: return AW'('h020 + 4 * ($urandom % (OWNW + 1)));
      3: return AW'('h080 + 4 * ($urandom % 3));
      7: return AW'($urandom);
      default: return AW'(TB + 8 * ($urandom % (NP + 2)) + 4 * ($urandom % 2));
    endcase
  endfunction

  initial begin
    #(64'd20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [31:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1", "pad_oe at reset", 64'(poe), 0);
    rst_n = 1'b1;
    op(1, 0, AW'(TB), 0, 0, "R1");
    op(1, 0, AW'(TB + 8 * (NP - 1) + 4), 0, 0, "R1");
    op(1, 0, 'h00C, 0, 0, "R3");
    op(1, 1, 'h00C, 32'hFFFF_FFFF, 0, "");
    op(1, 0, 'h00C, 0, 0, "R3");
    op(1, 1, AW'(TB + 40), 32'hFFFF_FFFF, '1, "");
    op(1, 0, AW'(TB + 40), 0, '1, "R4");
    op(1, 1, AW'(TB + 40), 32'h1, '1, "");
    op(1, 1, AW'(TB + 44), 32'hFFFF_FFFF, '1, "");
    op(1, 0, AW'(TB + 44), 0, '1, "R5");
    op(1, 1, 'h010, 32'hFFFF_FFFF, 0, "");
    op(1, 0, 'h010, 0, 0, "R8");
    op(1, 1, 'h020, 32'h0000_0010, 0, "");
    op(1, 1, AW'(TB + 8), 32'h1, 0, "");
    op(1, 0, AW'(TB + 8), 0, 0, "R11");
    op(1, 0, 'h020, 0, 0, "R9");
    op(1, 1, 'h020, 0, 0, "");
    op(1, 0, AW'(TB + 8), 0, 0, "R11");
    op(1, 1, 'h084, 32'hFFFF_FFFF, 0, "");
    op(1, 0, 'h084, 0, 0, "R10");
    op(1, 1, 'h044, 32'hFFFF_FFFF, 0, "");
    op(1, 0, 'h044, 0, 0, "R12");
    op(1, 1, AW'(TB + 8 * NP), 32'hFFFF_FFFF, 0, "");
    op(1, 0, AW'(TB + 8 * NP), 0, 0, "R12");
    op(1, 1, AW'(TB + 17), 32'h1, 0, "");
    op(1, 0, AW'(TB + 17), 0, 0, "R12");
    op(1, 1, AW'(TB + 24), 32'h0, '1, "");
    op(0, 0, 0, 0, '1, "");
    op(1, 0, AW'(TB + 24), 0, '1, "R7");
    op(1, 1, AW'(TB + 24), 32'h200, 0, "");
    op(0, 0, 0, 0, 0, "");
    op(1, 0, AW'(TB + 24), 0, 0, "R7");
    op(1, 1, AW'(TB + 24), 32'h1080_0000, 0, "");
    op(0, 0, 0, 0, 0, "");
    op(1, 0, AW'(TB + 24), 0, 0, "R7");
    op(1, 1, AW'(TB + 24), 32'h0, 0, "");
    op(0, 0, 0, 0, 0, "");
    op(1, 0, AW'(TB + 24), 0, 0, "R7");
    for (int k = 0; k < 2500; k++) begin
      a = raddr();
      d = $urandom;
      if (in_own(a) && ($urandom % 4 != 0)) d = 0;
      if (in_tbl(a) && !a[2] && $urandom % 2) d[13:10] = 0;
      op($urandom % 4 != 0, $urandom % 2, a, d, rpins(), "");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule